// File: doc/BRIEF.md
# Buffered Dual-Alignment PWM Channel

This block is a single pulse-width-modulated output channel built around a CW-bit counter. The counter advances only on cycles where an external clock selector asserts a one-cycle `tick`, so the counter rate is set outside the block. Software-style register writes set the enable, polarity, alignment mode, period, duty and counter. The period and duty are counted in ticks. In left-aligned mode the counter ramps from zero up to period-1 and wraps. In center-aligned mode it ramps up, holds at the top for one tick, ramps back down and holds at zero, so the active pulse sits symmetrically in a cycle of twice the period.

Period and duty writes land in holding buffers. The comparator and counter use a separate active copy, which refreshes from the buffers at only three points: at the end of a period, on any counter write, and on every cycle the channel is disabled. The result is that a running waveform never shows a half-updated period. The alignment mode is locked while the channel runs. A period of zero behaves as a period of one.

Top module: `pwm_chan`

## Requirements
- R1: Address 0 is the control word, with bit 0 = enable, bit 1 = polarity and bit 2 = center mode. Addresses 1, 2 and 3 write the period, the duty and the counter. After reset the channel is disabled with polarity 0. While disabled, `pwm_out` holds the inactive level, which is the inverse of the polarity bit. The output is registered and lags the counter by one clock.
- R2: With polarity 1 the active level is high. With polarity 0 the active level is low, and the waveform has the same timing.
- R3: In left-aligned mode the counter runs 0..P-1 and wraps. The output is active while count < D, which gives D active ticks in every P ticks.
- R4: In center-aligned mode one cycle lasts 2P ticks. The output is active for 2·min(D,P) ticks, and these form one contiguous run per cycle.
- R5: A write to the center bit while the channel is enabled is ignored. The mode in force is kept.
- R6: Period and duty writes do not change the waveform until a period ends, the counter is written, or the channel is disabled.
- R7: A counter write, with any data, sets the counter to zero, reloads period and duty from the buffers, and in center mode restarts the count upward.
- R8: A duty of 0 keeps the output inactive for the whole cycle. A duty of P or more keeps it active for the whole cycle.
- R9: The counter advances only on clocks where `tick` is high. With `tick` low the output holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter clock-enable from the clock selector |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 period, 2 duty, 3 counter) |
| wr_data | input | CW | Write data |
| pwm_out | output | 1 | PWM output pin |

## Verification
A table of configurations covers both polarities, both alignments, duties of zero, of exactly P and above P, a period of one, and the full 8-bit range. Each configuration counts the active clocks over a window that spans whole cycles, so the result does not depend on phase. A wrong count separates left from center timing and points to an error in the compare rule at its edges. A stalled `tick` freezes the counter, which lets the buffered duty be observed unchanged until a counter write applies it. The longest active run tells a locked-out mode change apart from one that took effect. A down-counting phase followed by a counter write and a single tick shows whether the upward restart happens.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_PER  = 2'd1,
    ADDR_DUTY = 2'd2,
    ADDR_CNT  = 2'd3
  } pwm_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_POL_BIT = 1;
  localparam int CTRL_CTR_BIT = 2;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          period_end,
  output logic          en,
  output logic          pol,
  output logic          center,
  output logic [CW-1:0] per_act,
  output logic [CW-1:0] duty_act,
  output logic          cnt_wr
);
  logic [CW-1:0] per_buf, duty_buf;
  logic          ctrl_wr, per_wr, duty_wr, load_act;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign per_wr   = wr_en && (wr_addr == ADDR_PER);
  assign duty_wr  = wr_en && (wr_addr == ADDR_DUTY);
  assign cnt_wr   = wr_en && (wr_addr == ADDR_CNT);
  assign load_act = period_end || cnt_wr || !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      pol      <= 1'b0;
      center   <= 1'b0;
      per_buf  <= '0;
      duty_buf <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else begin
      if (ctrl_wr) begin
        en  <= wr_data[CTRL_EN_BIT];
        pol <= wr_data[CTRL_POL_BIT];
        if (!en) center <= wr_data[CTRL_CTR_BIT];
      end
      if (per_wr)  per_buf  <= wr_data;
      if (duty_wr) duty_buf <= wr_data;
      if (load_act) begin
        per_act  <= per_buf;
        duty_act <= duty_buf;
      end
    end
  end

  // R5
  align_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && ctrl_wr |=> $stable(center));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !period_end && !cnt_wr |=> $stable(per_act) && $stable(duty_act));
endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          center,
  input  logic          tick,
  input  logic          cnt_wr,
  input  logic [CW-1:0] per_act,
  output logic [CW-1:0] cnt,
  output logic          period_end
);
  // Highest count value for a period; a zero period acts as one.
  function automatic logic [CW-1:0] last_of(input logic [CW-1:0] p);
    return (p == '0) ? '0 : p - 1'b1;
  endfunction

  logic up;
  logic at_top;

  assign at_top     = cnt >= last_of(per_act);
  assign period_end = en && tick && !cnt_wr &&
                      (center ? (!up && cnt == '0) : at_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (!en || cnt_wr) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (tick) begin
      if (center) begin
        if (up) begin
          if (at_top) up <= 1'b0;
          else        cnt <= cnt + 1'b1;
        end else begin
          if (cnt == '0) up <= 1'b1;
          else           cnt <= cnt - 1'b1;
        end
      end else begin
        cnt <= at_top ? '0 : cnt + 1'b1;
      end
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt <= last_of(per_act));

  // R9
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !tick && !cnt_wr |=> $stable(cnt));
endmodule

// File: rtl/pwm_chan_wave.sv
module pwm_chan_wave #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pol,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] duty_act,
  output logic          pwm_out
);
  function automatic logic in_active(input logic [CW-1:0] c,
                                     input logic [CW-1:0] d);
    return c < d;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)  pwm_out <= 1'b1;
    else if (en) pwm_out <= in_active(cnt, duty_act) ? pol : !pol;
    else         pwm_out <= !pol;
  end

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pwm_out == !$past(pol));

  // R8
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && duty_act == '0 |=> pwm_out == !$past(pol));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_out
);
  logic          en, pol, center, cnt_wr, period_end;
  logic [CW-1:0] per_act, duty_act, cnt;

  pwm_chan_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period_end(period_end), .en(en), .pol(pol),
    .center(center), .per_act(per_act), .duty_act(duty_act), .cnt_wr(cnt_wr)
  );

  pwm_chan_counter #(.CW(CW)) u_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .center(center), .tick(tick),
    .cnt_wr(cnt_wr), .per_act(per_act), .cnt(cnt), .period_end(period_end)
  );

  pwm_chan_wave #(.CW(CW)) u_wave (
    .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .cnt(cnt),
    .duty_act(duty_act), .pwm_out(pwm_out)
  );
endmodule

// File: tb/test_pwm_chan.sv
`timescale 1ns/1ps
module test_pwm_chan;
  localparam int CW = 8;

  typedef struct packed {
    logic        pol;
    logic        ctr;
    logic [7:0]  per;
    logic [7:0]  dty;
    logic [15:0] act_per_cycle;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd10,  8'd3,   16'd3},
    '{1'b0, 1'b0, 8'd10,  8'd3,   16'd3},
    '{1'b1, 1'b1, 8'd10,  8'd3,   16'd6},
    '{1'b0, 1'b1, 8'd10,  8'd7,   16'd14},
    '{1'b1, 1'b0, 8'd8,   8'd0,   16'd0},
    '{1'b1, 1'b0, 8'd8,   8'd8,   16'd8},
    '{1'b1, 1'b1, 8'd6,   8'd9,   16'd12},
    '{1'b1, 1'b0, 8'd1,   8'd1,   16'd1},
    '{1'b1, 1'b1, 8'd255, 8'd128, 16'd256},
    '{1'b1, 1'b0, 8'd200, 8'd100, 16'd100}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = 2'd0;
  logic [CW-1:0] wr_data = '0;
  logic          pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwm_chan #(.CW(CW)) i_pwm_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // control word: bit0 enable, bit1 polarity, bit2 center
  function automatic logic [CW-1:0] ctl(input logic e, input logic p, input logic c);
    return {{(CW-3){1'b0}}, c, p, e};
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic measure(input int n, input logic act_lvl,
                         output int act_cnt, output int run_max);
    int run;
    act_cnt = 0; run_max = 0; run = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out == act_lvl) begin
        act_cnt++; run++;
        if (run > run_max) run_max = run;
      end else run = 0;
    end
  endtask

  initial begin
    int ac, rm, len;
    string tag;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 reset idle level", pwm_out, 1);

    // table walk
    tick = 1'b1;
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, ctl(1'b0, VECS[v].pol, VECS[v].ctr));
      wr(2'd0, ctl(1'b0, VECS[v].pol, VECS[v].ctr));
      wr(2'd1, VECS[v].per);
      wr(2'd2, VECS[v].dty);
      wr(2'd0, ctl(1'b1, VECS[v].pol, VECS[v].ctr));
      len = VECS[v].ctr ? 2 * int'(VECS[v].per) : int'(VECS[v].per);
      wait_cyc(2 * len + 8);
      measure(4 * len, VECS[v].pol, ac, rm);
      tag = $sformatf("%s %s %s vec%0d",
                      VECS[v].ctr ? "R4" : "R3",
                      VECS[v].pol ? "R2" : "R2_lowactive",
                      (VECS[v].dty == 0 || VECS[v].dty >= VECS[v].per) ? "R8" : "R6", v);
      chk(tag, ac, 4 * int'(VECS[v].act_per_cycle));
    end

    // frozen counter: buffering and tick gating
    tick = 1'b0;
    wr(2'd0, ctl(1'b0, 1'b1, 1'b0));
    wr(2'd1, 8'd10);
    wr(2'd2, 8'd5);
    wr(2'd0, ctl(1'b1, 1'b1, 1'b0));
    wait_cyc(3);
    measure(20, 1'b1, ac, rm);
    chk("R9 output held without tick", ac, 20);
    wr(2'd2, 8'd0);
    wait_cyc(4);
    chk("R6 duty write buffered", pwm_out, 1);
    wr(2'd3, 8'd77);
    wait_cyc(3);
    chk("R7 counter write reloads duty", pwm_out, 0);
    wr(2'd2, 8'd5);
    wait_cyc(3);
    chk("R6 duty held until boundary", pwm_out, 0);
    tick = 1'b1;
    wait_cyc(30);
    measure(40, 1'b1, ac, rm);
    chk("R6 duty applied at period end", ac, 20);

    // alignment lock while running
    wr(2'd2, 8'd3);
    wr(2'd0, ctl(1'b1, 1'b1, 1'b1));
    wait_cyc(30);
    measure(40, 1'b1, ac, rm);
    chk("R5 center write ignored (run)", rm, 3);
    chk("R5 center write ignored (count)", ac, 12);
    wr(2'd0, ctl(1'b0, 1'b1, 1'b1));
    wr(2'd0, ctl(1'b0, 1'b1, 1'b1));
    wr(2'd0, ctl(1'b1, 1'b1, 1'b1));
    wait_cyc(50);
    measure(40, 1'b1, ac, rm);
    chk("R4 center run length", rm, 6);

    // center direction restart on counter write
    tick = 1'b0;
    wr(2'd0, ctl(1'b0, 1'b1, 1'b1));
    wr(2'd1, 8'd4);
    wr(2'd2, 8'd1);
    wr(2'd0, ctl(1'b1, 1'b1, 1'b1));
    for (int k = 0; k < 5; k++) pulse_tick();
    wr(2'd3, 8'd0);
    wait_cyc(2);
    chk("R7 counter write zeroes count", pwm_out, 1);
    pulse_tick();
    wait_cyc(2);
    chk("R7 center restarts upward", pwm_out, 0);

    // disable levels
    wr(2'd0, ctl(1'b0, 1'b1, 1'b0));
    wait_cyc(3);
    chk("R1 disabled idle pol1", pwm_out, 0);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b0));
    wait_cyc(3);
    chk("R1 disabled idle pol0", pwm_out, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule